// File: doc/BRIEF.md
# Transmit Checksum Offload Inserter

This block is a store-and-forward stage on the transmit side of an Ethernet controller. A byte-wide frame stream enters, is held whole in an internal buffer, and leaves on a second byte-wide stream with valid/ready flow control. Beside the data stream, a short sideband header stream carries per-frame checksum settings: an insert enable, the byte offset where summing starts, the byte offset where the result goes, and a 16-bit seed. While the frame is stored, a ones'-complement sum is built on the fly. When insertion is enabled, the folded and inverted result replaces two bytes of the frame on their way out, high byte first.

The stage also applies the transmit control word. It drops frames while transmit is disabled, drops frames that do not fit the buffer, and drops frames of 1519 to 1522 bytes when neither jumbo nor VLAN sizes are allowed. A control write with the soft-reset bit restores the default control value and discards a frame that is being received. Every sent frame adds its length to a byte counter and raises a sticky transmit-complete status bit.

Top module: `txcs_inserter`

## Requirements
- R1: After reset the control word reads 0x5800_0000, `in_ready` is 1, `out_valid` is 0, `tx_bytes` is 0, `status` is 0 and `hdr_err` is 0.
- R2: A header packet of exactly five 32-bit words, the fifth carrying `hdr_last`, replaces the active checksum settings. Word 0 bit 0 is the insert enable, word 1 bits [31:16] the start offset and bits [15:0] the write offset, word 2 bits [15:0] the seed; words 3 and 4 are ignored. Any other packet length pulses `hdr_err` for one cycle after its last word and leaves the settings unchanged.
- R3: With insertion disabled, a frame leaves byte for byte as it entered, with `out_last` on its final byte only.
- R4: With insertion enabled, the result is the ones'-complement sum, with end-around carry, of 16-bit words taken from the start offset to the frame end, plus the seed. The byte at an even distance from the start is the high byte of a word, and an odd final byte is padded with a zero low byte. The result is inverted. Its high byte replaces the byte at the write offset and its low byte the byte after it. A replaced position at or beyond the frame length is not sent.
- R5: A frame whose first byte arrives while control bit 28 (transmit enable) is 0 is consumed and produces no output.
- R6: A frame longer than `BUF_BYTES` is consumed and dropped, and the next frame is sent normally; a frame of exactly `BUF_BYTES` is sent.
- R7: With control bit 30 (jumbo) and bit 27 (VLAN) both 0, frames of 1519 to 1522 bytes are dropped, while 1518 and 1523 bytes are sent; with either bit set, those lengths are sent.
- R8: A control write without bit 31 stores the written value. A write with bit 31 set loads 0x5800_0000 and discards the frame being received.
- R9: When the last byte of a frame is accepted at the output, `tx_bytes` grows by the frame length and `status` bit 5 is set. Writing a 1 to a bit of `sts_clr` clears that status bit.
- R10: While `out_valid` is high and `out_ready` low, `out_data` and `out_last` hold. `in_ready` is 0 from the end of a stored frame until its last byte is sent.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_wr | input | 1 | Control word write strobe |
| cfg_wdata | input | 32 | Control word write value |
| ctrl_q | output | 32 | Current control word |
| hdr_valid | input | 1 | Header word valid |
| hdr_data | input | 32 | Header word |
| hdr_last | input | 1 | Last word of the header packet |
| hdr_err | output | 1 | One-cycle pulse: header packet had the wrong length |
| in_valid | input | 1 | Input frame byte valid |
| in_data | input | 8 | Input frame byte |
| in_last | input | 1 | Final byte of the input frame |
| in_ready | output | 1 | Stage accepts input bytes |
| out_valid | output | 1 | Output frame byte valid |
| out_data | output | 8 | Output frame byte |
| out_last | output | 1 | Final byte of the output frame |
| out_ready | input | 1 | Downstream accepts output bytes |
| tx_bytes | output | CNT_W | Total bytes of sent frames |
| status | output | 8 | Sticky status, bit 5 transmit complete |
| sts_clr | input | 8 | Write-one-to-clear mask for `status` |

## Verification
The bench builds the block with `BUF_BYTES` set to 2048. This keeps the overflow boundary at 2048 and 2049 bytes within a few thousand cycles, while the 1518 to 1523 byte size rules still fit in the buffer. Short frames of 8 to 12 bytes are swept over every start offset from 0 to 3, with write offsets at the head, inside, on the last byte and past the end, and with two seeds. This covers even and odd lengths, odd start parity, a zero-padded tail and a truncated patch, all against an end-around-carry reference computed in the bench. Half of the sweep runs with output backpressure.

// File: rtl/txcs_pkg.sv
package txcs_pkg;
  localparam int          HDR_WORDS    = 5;
  localparam int          B_VLAN       = 27;
  localparam int          B_EN         = 28;
  localparam int          B_JUMBO      = 30;
  localparam int          B_SRST       = 31;
  localparam int          STS_TXDONE   = 5;
  localparam logic [31:0] CTRL_DEFAULT = 32'h5800_0000;

  typedef struct packed {
    logic        ins_en;
    logic [15:0] start;
    logic [15:0] woff;
    logic [15:0] seed;
  } csum_hdr_t;

  // Contribution of one byte at frame position pos to the running sum.
  function automatic logic [31:0] csum_term(input logic [31:0] pos,
                                            input logic [15:0] start,
                                            input logic [7:0]  b);
    if (pos < {16'd0, start}) return 32'd0;
    if (pos[0] ^ start[0])    return {24'd0, b};
    return {16'd0, b, 8'd0};
  endfunction

  // Two end-around folds bring any 32-bit sum down to 16 bits.
  function automatic logic [15:0] csum_fold(input logic [31:0] s);
    logic [31:0] t;
    t = {16'd0, s[31:16]} + {16'd0, s[15:0]};
    t = {16'd0, t[31:16]} + {16'd0, t[15:0]};
    return t[15:0];
  endfunction

  function automatic logic size_rejected(input logic [31:0] len,
                                         input logic jumbo, input logic vlan,
                                         input int std_max, input int vlan_max);
    return !jumbo && !vlan && (len > 32'(std_max)) && (len <= 32'(vlan_max));
  endfunction
endpackage

// File: rtl/txcs_ctrl_reg.sv
module txcs_ctrl_reg
  import txcs_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cfg_wr,
  input  logic [31:0] cfg_wdata,
  output logic [31:0] ctrl_q,
  output logic        soft_rst
);
  assign soft_rst = cfg_wr && cfg_wdata[B_SRST];

  always_ff @(posedge clk) begin
    if (!rst_n)        ctrl_q <= CTRL_DEFAULT;
    else if (soft_rst) ctrl_q <= CTRL_DEFAULT;
    else if (cfg_wr)   ctrl_q <= cfg_wdata;
  end

  // R8: soft reset restores the default word
  a_r8_soft_default: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_wr && cfg_wdata[B_SRST]) |=> (ctrl_q == CTRL_DEFAULT));
  // R8: without a write the word holds
  a_r8_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_wr |=> $stable(ctrl_q));
endmodule

// File: rtl/txcs_hdr_capture.sv
module txcs_hdr_capture
  import txcs_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        hdr_valid,
  input  logic [31:0] hdr_data,
  input  logic        hdr_last,
  output csum_hdr_t   hdr_q,
  output logic        hdr_err,
  output logic        hdr_load
);
  localparam logic [2:0] LAST_IDX = 3'(HDR_WORDS - 1);

  logic [2:0] idx;
  csum_hdr_t  shadow;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      idx      <= '0;
      shadow   <= '0;
      hdr_q    <= '0;
      hdr_err  <= 1'b0;
      hdr_load <= 1'b0;
    end else begin
      hdr_err  <= 1'b0;
      hdr_load <= 1'b0;
      if (hdr_valid) begin
        case (idx)
          3'd0: shadow.ins_en <= hdr_data[0];
          3'd1: begin
            shadow.start <= hdr_data[31:16];
            shadow.woff  <= hdr_data[15:0];
          end
          3'd2: shadow.seed <= hdr_data[15:0];
          default: ;
        endcase
        if (hdr_last) begin
          idx <= '0;
          if (idx == LAST_IDX) begin
            hdr_q    <= shadow;
            hdr_load <= 1'b1;
          end else begin
            hdr_err <= 1'b1;
          end
        end else if (idx != 3'd7) begin
          idx <= idx + 3'd1;
        end
      end
    end
  end

  // R2: a length error is flagged only right after a packet end
  a_r2_err_at_last: assert property (@(posedge clk) disable iff (!rst_n)
    hdr_err |-> $past(hdr_valid && hdr_last));
  // R2: settings change only on a correct-length packet
  a_r2_settings_stable: assert property (@(posedge clk) disable iff (!rst_n)
    !hdr_load |-> $stable(hdr_q));
endmodule

// File: rtl/txcs_sum_acc.sv
module txcs_sum_acc
  import txcs_pkg::*;
#(
  parameter int PW = 13
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          add_en,
  input  logic          restart,
  input  logic [PW-1:0] pos,
  input  logic [15:0]   start,
  input  logic [7:0]    din,
  output logic [31:0]   acc
);
  logic [31:0] term;
  assign term = csum_term(32'(pos), start, din);

  always_ff @(posedge clk) begin
    if (!rst_n)      acc <= '0;
    else if (add_en) acc <= (restart ? 32'd0 : acc) + term;
  end

  // R4: the running sum moves only when a byte is stored
  a_r4_acc_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !add_en |=> $stable(acc));
endmodule

// File: rtl/txcs_inserter.sv
module txcs_inserter
  import txcs_pkg::*;
#(
  parameter int BUF_BYTES = 4096,
  parameter int CNT_W     = 48,
  parameter int STD_MAX   = 1518,
  parameter int VLAN_MAX  = 1522
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_wr,
  input  logic [31:0]      cfg_wdata,
  output logic [31:0]      ctrl_q,
  input  logic             hdr_valid,
  input  logic [31:0]      hdr_data,
  input  logic             hdr_last,
  output logic             hdr_err,
  input  logic             in_valid,
  input  logic [7:0]       in_data,
  input  logic             in_last,
  output logic             in_ready,
  output logic             out_valid,
  output logic [7:0]       out_data,
  output logic             out_last,
  input  logic             out_ready,
  output logic [CNT_W-1:0] tx_bytes,
  output logic [7:0]       status,
  input  logic [7:0]       sts_clr
);
  localparam int PW = $clog2(BUF_BYTES + 1);
  localparam int AW = $clog2(BUF_BYTES);
  localparam logic [PW-1:0] BUF_LIM = PW'(BUF_BYTES);

  typedef enum logic [1:0] {S_FILL, S_CALC, S_SEND} st_t;

  st_t         st;
  logic        soft_rst, hdr_load;
  csum_hdr_t   hdr_q, fh;
  logic [31:0] acc;
  logic [15:0] res;
  logic [PW-1:0] wr_ptr, rd_ptr, flen;
  logic        mid, drop;
  logic [7:0]  mem [BUF_BYTES];

  // Named internal events
  logic        byte_acc, first, drop_now, ovf, store, size_bad, frame_ok;
  logic        fire, fire_last;
  logic [15:0] start_eff;

  txcs_ctrl_reg u_ctrl (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_wdata(cfg_wdata),
    .ctrl_q(ctrl_q), .soft_rst(soft_rst));

  txcs_hdr_capture u_hdr (
    .clk(clk), .rst_n(rst_n), .hdr_valid(hdr_valid), .hdr_data(hdr_data),
    .hdr_last(hdr_last), .hdr_q(hdr_q), .hdr_err(hdr_err), .hdr_load(hdr_load));

  assign in_ready  = (st == S_FILL);
  assign byte_acc  = in_valid && in_ready;
  assign first     = !mid;
  assign drop_now  = first ? !ctrl_q[B_EN] : drop;
  assign ovf       = !drop_now && (wr_ptr == BUF_LIM);
  assign store     = byte_acc && !drop_now && !ovf && !soft_rst;
  assign size_bad  = size_rejected(32'(wr_ptr) + 32'd1, ctrl_q[B_JUMBO],
                                   ctrl_q[B_VLAN], STD_MAX, VLAN_MAX);
  assign frame_ok  = store && in_last && !size_bad;
  assign start_eff = first ? hdr_q.start : fh.start;
  assign fire      = out_valid && out_ready;
  assign fire_last = fire && out_last;

  txcs_sum_acc #(.PW(PW)) u_sum (
    .clk(clk), .rst_n(rst_n), .add_en(store), .restart(first),
    .pos(wr_ptr), .start(start_eff), .din(in_data), .acc(acc));

  function automatic logic [7:0] patch(input logic [7:0] b, input logic [PW-1:0] i,
                                       input csum_hdr_t h, input logic [15:0] r);
    if (!h.ins_en) return b;
    if (17'(i) == 17'(h.woff))         return r[15:8];
    if (17'(i) == 17'(h.woff) + 17'd1) return r[7:0];
    return b;
  endfunction

  always_ff @(posedge clk) begin
    if (store) mem[wr_ptr[AW-1:0]] <= in_data;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st        <= S_FILL;
      wr_ptr    <= '0;
      rd_ptr    <= '0;
      flen      <= '0;
      mid       <= 1'b0;
      drop      <= 1'b0;
      fh        <= '0;
      res       <= '0;
      out_valid <= 1'b0;
      out_data  <= '0;
      out_last  <= 1'b0;
      tx_bytes  <= '0;
      status    <= '0;
    end else begin
      status <= status & ~sts_clr;
      case (st)
        S_FILL: begin
          if (soft_rst) begin
            wr_ptr <= '0;
            if (byte_acc) begin
              mid  <= !in_last;
              drop <= !in_last;
            end else begin
              drop <= mid;
            end
          end else if (byte_acc) begin
            if (first) fh <= hdr_q;
            if (in_last) begin
              mid    <= 1'b0;
              drop   <= 1'b0;
              wr_ptr <= '0;
              if (frame_ok) begin
                flen <= wr_ptr + PW'(1);
                st   <= S_CALC;
              end
            end else begin
              mid  <= 1'b1;
              drop <= drop_now || ovf;
              if (store) wr_ptr <= wr_ptr + PW'(1);
              else       wr_ptr <= '0;
            end
          end
        end
        S_CALC: begin
          res    <= ~csum_fold(acc + {16'd0, fh.seed});
          rd_ptr <= '0;
          st     <= S_SEND;
        end
        S_SEND: begin
          if (!out_valid || out_ready) begin
            if (rd_ptr < flen) begin
              out_data  <= patch(mem[rd_ptr[AW-1:0]], rd_ptr, fh, res);
              out_valid <= 1'b1;
              out_last  <= (rd_ptr == flen - PW'(1));
              rd_ptr    <= rd_ptr + PW'(1);
            end else begin
              out_valid <= 1'b0;
              out_last  <= 1'b0;
            end
          end
          if (fire_last) begin
            st                 <= S_FILL;
            tx_bytes           <= tx_bytes + CNT_W'(flen);
            status[STS_TXDONE] <= 1'b1;
          end
        end
        default: st <= S_FILL;
      endcase
    end
  end

  // R10: output holds under backpressure
  a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data) && $stable(out_last)));
  // R10: no input is taken while a frame is going out
  a_r10_no_overlap: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> !in_ready);
  // R9: completion sets the status bit
  a_r9_done_sets: assert property (@(posedge clk) disable iff (!rst_n)
    fire_last |=> status[STS_TXDONE]);
  // R9: the byte counter moves only on a frame completion
  a_r9_bytes_move: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_bytes != $past(tx_bytes)) |-> $past(fire_last));
  // R6: the store pointer never passes the buffer size
  a_r6_ptr_bound: assert property (@(posedge clk) disable iff (!rst_n)
    wr_ptr <= BUF_LIM);
endmodule

// File: tb/txcs_inserter_bench.sv
module txcs_inserter_bench;
  localparam int BUF   = 2048;
  localparam int CNT_W = 48;
  localparam int MAXF  = 2100;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_wr = 1'b0;
  logic [31:0] cfg_wdata = '0;
  logic [31:0] ctrl_q;
  logic hdr_valid = 1'b0;
  logic [31:0] hdr_data = '0;
  logic hdr_last = 1'b0;
  logic hdr_err;
  logic in_valid = 1'b0;
  logic [7:0] in_data = '0;
  logic in_last = 1'b0;
  logic in_ready;
  logic out_valid;
  logic [7:0] out_data;
  logic out_last;
  logic out_ready = 1'b1;
  logic [CNT_W-1:0] tx_bytes;
  logic [7:0] status;
  logic [7:0] sts_clr = '0;

  always #2.5 clk = ~clk;

  txcs_inserter #(.BUF_BYTES(BUF), .CNT_W(CNT_W)) u_txcs_inserter (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_wdata(cfg_wdata), .ctrl_q(ctrl_q),
    .hdr_valid(hdr_valid), .hdr_data(hdr_data), .hdr_last(hdr_last), .hdr_err(hdr_err),
    .in_valid(in_valid), .in_data(in_data), .in_last(in_last), .in_ready(in_ready),
    .out_valid(out_valid), .out_data(out_data), .out_last(out_last), .out_ready(out_ready),
    .tx_bytes(tx_bytes), .status(status), .sts_clr(sts_clr));

  int total = 0;
  int bad = 0;
  bit finished = 1'b0;
  bit bp_mode = 1'b0;
  int bpc = 0;
  logic [7:0] fr  [MAXF];
  logic [7:0] cap [MAXF];
  int ncap = 0;
  int lastpos = -1;
  int overlap = 0;
  longint exp_bytes = 0;

  task automatic chk(input bit ok, input string tag, input longint act, input longint expv);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, expv);
    end
  endtask

  // Output capture, sampled away from the rising edge
  always @(negedge clk) begin
    if (out_valid && out_ready) begin
      if (ncap < MAXF) cap[ncap] = out_data;
      if (out_last) lastpos = ncap;
      ncap++;
    end
    if (out_valid && in_ready) overlap++;
  end

  // Output backpressure pattern
  initial begin
    forever begin
      @(posedge clk); #1;
      out_ready = bp_mode ? ((bpc % 3) != 2) : 1'b1;
      bpc++;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic cyc(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic wr_ctrl(input logic [31:0] v);
    cfg_wr = 1'b1; cfg_wdata = v;
    @(posedge clk); #1;
    cfg_wr = 1'b0;
  endtask

  task automatic send_hdr(input int nw, input logic [31:0] w0, input logic [31:0] w1,
                          input logic [31:0] w2);
    for (int i = 0; i < nw; i++) begin
      hdr_valid = 1'b1;
      hdr_data  = (i == 0) ? w0 : (i == 1) ? w1 : (i == 2) ? w2 : 32'hDEAD_0000 + 32'(i);
      hdr_last  = (i == nw - 1);
      @(posedge clk); #1;
    end
    hdr_valid = 1'b0; hdr_last = 1'b0;
  endtask

  task automatic put_byte(input logic [7:0] d, input bit lst);
    bit ok;
    in_valid = 1'b1; in_data = d; in_last = lst;
    do begin
      @(negedge clk); ok = in_ready;
      @(posedge clk); #1;
    end while (!ok);
    in_valid = 1'b0; in_last = 1'b0;
  endtask

  task automatic fill(input int len, input int salt);
    for (int i = 0; i < len; i++) fr[i] = 8'((i * 37 + salt * 11 + 5) ^ (i >> 3));
  endtask

  task automatic send_frame(input int len);
    ncap = 0; lastpos = -1;
    for (int i = 0; i < len; i++) put_byte(fr[i], i == len - 1);
  endtask

  task automatic wait_out(input int len);
    for (int k = 0; k < len * 4 + 40 && ncap < len; k++) @(posedge clk);
    cyc(6);
  endtask

  function automatic logic [15:0] ref_sum(input int len, input int start, input logic [15:0] seed);
    logic [16:0] s;
    logic [15:0] w;
    s = 17'(seed);
    for (int i = start; i < len; i += 2) begin
      w = {fr[i], (i + 1 < len) ? fr[i + 1] : 8'h00};
      s = s + 17'(w);
      if (s[16]) s = {1'b0, s[15:0]} + 17'd1;
    end
    return ~s[15:0];
  endfunction

  // Sends fr[0..len-1] and compares the output with the patched reference
  task automatic frame_pass(input string tag, input int len, input bit en, input int start,
                            input int woff, input logic [15:0] seed);
    logic [7:0] expv [MAXF];
    logic [15:0] r;
    int mis;
    int first_mis;
    for (int i = 0; i < len; i++) expv[i] = fr[i];
    if (en) begin
      r = ref_sum(len, start, seed);
      if (woff < len) expv[woff] = r[15:8];
      if (woff + 1 < len) expv[woff + 1] = r[7:0];
    end
    send_frame(len);
    wait_out(len);
    mis = 0; first_mis = -1;
    for (int i = 0; i < len && i < ncap; i++)
      if (cap[i] !== expv[i]) begin
        mis++;
        if (first_mis < 0) first_mis = i;
      end
    chk(ncap == len && lastpos == len - 1, {tag, " length"}, ncap, len);
    if (first_mis >= 0) chk(1'b0, {tag, " data"}, cap[first_mis], expv[first_mis]);
    else chk(1'b1, {tag, " data"}, 0, 0);
    exp_bytes += len;
    chk(tx_bytes == CNT_W'(exp_bytes), {tag, " R9 bytes"}, tx_bytes, exp_bytes);
    chk(status[5] == 1'b1, {tag, " R9 status"}, status, 8'h20);
  endtask

  task automatic frame_drop(input string tag, input int len);
    send_frame(len);
    cyc(40);
    chk(ncap == 0, tag, ncap, 0);
    chk(tx_bytes == CNT_W'(exp_bytes), {tag, " bytes"}, tx_bytes, exp_bytes);
  endtask

  initial begin
    cyc(4);
    rst_n = 1'b1;
    cyc(1);
    @(negedge clk);
    // R1 reset state
    chk(ctrl_q == 32'h5800_0000, "R1 ctrl", ctrl_q, 32'h5800_0000);
    chk(in_ready == 1'b1 && out_valid == 1'b0, "R1 handshake", {in_ready, out_valid}, 2'b10);
    chk(tx_bytes == '0 && status == '0 && hdr_err == 1'b0, "R1 counters", status, 0);
    @(posedge clk); #1;

    // R3 pass-through with insertion off
    send_hdr(5, 32'h0, {16'd0, 16'd2}, 32'h0);
    fill(60, 1);
    frame_pass("R3 passthrough", 60, 1'b0, 0, 2, 16'h0);

    // R2 valid header, then wrong-length headers leave it unchanged
    send_hdr(5, 32'h1, {16'd14, 16'd4}, 32'h0000_1234);
    chk(hdr_err == 1'b0, "R2 good header no error", hdr_err, 0);
    send_hdr(4, 32'h0, {16'd0, 16'd0}, 32'h0);
    @(negedge clk);
    chk(hdr_err == 1'b1, "R2 short header error", hdr_err, 1);
    @(posedge clk); #1;
    send_hdr(6, 32'h0, {16'd1, 16'd1}, 32'h0);
    @(negedge clk);
    chk(hdr_err == 1'b1, "R2 long header error", hdr_err, 1);
    @(posedge clk); #1;
    fill(40, 2);
    frame_pass("R2 header kept", 40, 1'b1, 14, 4, 16'h1234);

    // R4 sweep over start parity, length parity, write position and seed
    for (int st = 0; st < 4; st++)
      for (int ln = 8; ln < 13; ln++)
        for (int wk = 0; wk < 4; wk++)
          for (int sd = 0; sd < 2; sd++) begin
            int wo;
            logic [15:0] seed;
            wo   = (wk == 0) ? 0 : (wk == 1) ? ln - 2 : (wk == 2) ? ln - 1 : ln + 3;
            seed = sd ? 16'hFFFF : 16'h00A5;
            bp_mode = sd[0];
            send_hdr(5, 32'h1, {16'(st), 16'(wo)}, {16'hBEEF, seed});
            fill(ln, st * 7 + ln + wk);
            if (sd == 1 && wk == 0) for (int i = 0; i < ln; i++) fr[i] = 8'hFF;
            frame_pass("R4 checksum", ln, 1'b1, st, wo, seed);
          end
    bp_mode = 1'b0;
    cyc(2);
    chk(overlap == 0, "R10 no input during output", overlap, 0);

    // R10 longer frame under backpressure
    bp_mode = 1'b1;
    send_hdr(5, 32'h1, {16'd3, 16'd20}, 32'h0000_0101);
    fill(101, 9);
    frame_pass("R10 backpressure", 101, 1'b1, 3, 20, 16'h0101);
    bp_mode = 1'b0;
    send_hdr(5, 32'h0, 32'h0, 32'h0);

    // R9 status clear
    sts_clr = 8'h20; @(posedge clk); #1; sts_clr = 8'h00;
    @(negedge clk);
    chk(status == 8'h00, "R9 status clear", status, 0);
    @(posedge clk); #1;

    // R5 transmit disabled
    wr_ctrl(32'h4800_0000);
    @(negedge clk);
    chk(ctrl_q == 32'h4800_0000, "R8 stored value", ctrl_q, 32'h4800_0000);
    @(posedge clk); #1;
    fill(20, 3);
    frame_drop("R5 disabled drop", 20);

    // R7 size rules with jumbo and VLAN clear
    wr_ctrl(32'h1000_0000);
    fill(1523, 4);
    frame_pass("R7 1518 sent", 1518, 1'b0, 0, 0, 16'h0);
    frame_drop("R7 1519 drop", 1519);
    frame_drop("R7 1520 drop", 1520);
    frame_drop("R7 1522 drop", 1522);
    frame_pass("R7 1523 sent", 1523, 1'b0, 0, 0, 16'h0);
    wr_ctrl(32'h1800_0000);
    frame_pass("R7 1520 with VLAN", 1520, 1'b0, 0, 0, 16'h0);

    // R6 buffer limit
    wr_ctrl(32'h5000_0000);
    fill(2049, 5);
    frame_pass("R6 full buffer sent", 2048, 1'b0, 0, 0, 16'h0);
    frame_drop("R6 overflow drop", 2049);
    fill(30, 6);
    frame_pass("R6 after overflow", 30, 1'b0, 0, 0, 16'h0);

    // R8 soft reset discards the frame in progress
    wr_ctrl(32'h1000_0000);
    fill(20, 7);
    ncap = 0; lastpos = -1;
    for (int i = 0; i < 10; i++) put_byte(fr[i], 1'b0);
    wr_ctrl(32'h8000_0000);
    @(negedge clk);
    chk(ctrl_q == 32'h5800_0000, "R8 soft reset value", ctrl_q, 32'h5800_0000);
    @(posedge clk); #1;
    for (int i = 10; i < 20; i++) put_byte(fr[i], i == 19);
    cyc(40);
    chk(ncap == 0, "R8 frame discarded", ncap, 0);
    fill(25, 8);
    frame_pass("R8 next frame", 25, 1'b0, 0, 0, 16'h0);

    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule